// File: doc/BRIEF.md
# Low-Address Protection and Prefix Mapping Stage

This stage takes a real address from a CPU access and does two things in one registered step. First it decides whether the access falls under low-address protection. Two 512-byte windows are guarded: bytes 0 to 511 and bytes 4096 to 4607. A store into either window is refused. Second, it converts the real address to an absolute address. The per-CPU prefix register swaps the first 8 KiB of storage with the 8 KiB block the prefix points at.

Protection takes effect only when the enable control is set. With address translation (DAT) off, an enabled protection always applies. With DAT on, it applies only if the private-space bit is clear in the descriptor of the space the access uses. If the page holding the address is a guarded page, the stage raises a flag telling later caches not to keep write permission for that page. It raises this flag even when the access itself is allowed. An access-register mode request under DAT is not evaluated. It is reported as unsupported.

Top module: `lowprot_prefix_map`

## Requirements
- R1: While reset is asserted and on the first cycle after it, rsp_valid, rsp_prot_exc, rsp_wr_inv and rsp_bad_mode are 0 and rsp_abs is 0. The prefix register resets to 0.
- R2: Each request sampled with req_valid high on a rising edge produces its result on the outputs after that edge, with rsp_valid high for exactly that one cycle. A cycle with req_valid low gives rsp_valid low and all flags low.
- R3: A store (req_kind 2'b01) to an address in 0..511 or 4096..4607, with protection active, sets rsp_prot_exc and rsp_wr_inv and gives rsp_abs 0. Loads (2'b00) and fetches (2'b10) never raise rsp_prot_exc.
- R4: With prot_en low, rsp_prot_exc and rsp_wr_inv stay low for every address and access kind.
- R5: With prot_en high and dat_on low, protection is active whatever the private-space bits and space_mode are.
- R6: With dat_on high, protection is active only if the private-space bit of the selected space is clear. space_mode 2'b00 selects priv_primary, 2'b10 selects priv_secondary, and 2'b11 selects priv_home.
- R7: With protection active, rsp_wr_inv is set when the address with its low 12 bits cleared is 0 or 4096. This holds for allowed accesses too, for example a store to 0x300 or a load from 0x10.
- R8: A real address below 0x2000 maps to the address plus the prefix.
- R9: An address from the prefix up to the prefix plus 0x1FFF maps to the address minus the prefix. Any other address maps to itself.
- R10: pfx_we high on a rising edge loads pfx_wdata with its low 13 bits cleared. The new prefix applies to requests sampled on later edges. A request on the same edge still uses the old prefix.
- R11: With dat_on high and space_mode 2'b01, the response sets rsp_bad_mode, keeps rsp_prot_exc and rsp_wr_inv low, and gives rsp_abs 0. With dat_on low, space_mode 2'b01 is evaluated normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Real address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch |
| dat_on | input | 1 | Address translation enabled |
| space_mode | input | 2 | 00 primary, 01 access-register, 10 secondary, 11 home |
| prot_en | input | 1 | Low-address protection enable |
| priv_primary | input | 1 | Private-space bit of primary descriptor |
| priv_secondary | input | 1 | Private-space bit of secondary descriptor |
| priv_home | input | 1 | Private-space bit of home descriptor |
| pfx_we | input | 1 | Load prefix register |
| pfx_wdata | input | AW | New prefix value |
| rsp_valid | output | 1 | Response present |
| rsp_abs | output | AW | Absolute address |
| rsp_prot_exc | output | 1 | Protection exception strobe |
| rsp_wr_inv | output | 1 | Do not cache write permission |
| rsp_bad_mode | output | 1 | Unsupported address-space mode |

## Verification
The only state in this block is the prefix register. A wrong value there shows up on the very next response that touches the low 8 KiB or the prefix block: the absolute address is off by the difference. It stays hidden for any address outside those two blocks. For that reason the bench drives addresses on both sides of every window edge, both right after each prefix load and on the same edge as the load. The protection decision depends only on the current request. A bad select of the private-space bit is therefore caught within one cycle, provided the bench varies the descriptor bits independently of the space selected.

// File: rtl/lowprot_prefix_map.sv
module lowprot_prefix_map #(
  parameter int AW       = 64,
  parameter int LOW_WIN  = 512,
  parameter int PG_BITS  = 12,
  parameter int PFX_BITS = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_kind,
  input  logic          dat_on,
  input  logic [1:0]    space_mode,
  input  logic          prot_en,
  input  logic          priv_primary,
  input  logic          priv_secondary,
  input  logic          priv_home,
  input  logic          pfx_we,
  input  logic [AW-1:0] pfx_wdata,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_abs,
  output logic          rsp_prot_exc,
  output logic          rsp_wr_inv,
  output logic          rsp_bad_mode
);
  localparam logic [AW-1:0] WIN     = AW'(LOW_WIN);
  localparam logic [AW-1:0] PG      = AW'(1) << PG_BITS;
  localparam logic [AW-1:0] SPAN    = AW'(1) << PFX_BITS;
  localparam logic [AW-1:0] PG_MASK = ~(PG - AW'(1));
  localparam logic [AW-1:0] PFX_MSK = ~(SPAN - AW'(1));
  localparam logic [1:0]    K_STORE = 2'b01;
  localparam logic [1:0]    M_AR    = 2'b01;

  function automatic logic in_window(input logic [AW-1:0] a);
    return (a < WIN) || (a >= PG && a < PG + WIN);
  endfunction

  logic [AW-1:0] pfx_q;
  logic          priv_sel, active, bad, inv, exc, in_pfx;
  logic [AW-1:0] mapped;

  always_comb begin
    case (space_mode)
      2'b00:   priv_sel = priv_primary;
      2'b10:   priv_sel = priv_secondary;
      2'b11:   priv_sel = priv_home;
      default: priv_sel = 1'b0;
    endcase
  end

  assign bad    = dat_on && space_mode == M_AR;
  assign active = prot_en && (!dat_on || !priv_sel) && !bad;
  assign inv    = active && in_window(req_addr & PG_MASK);
  assign exc    = inv && in_window(req_addr) && req_kind == K_STORE;
  assign in_pfx = req_addr >= pfx_q && req_addr < pfx_q + SPAN;

  always_comb begin
    if (req_addr < SPAN)   mapped = req_addr + pfx_q;
    else if (in_pfx)       mapped = req_addr - pfx_q;
    else                   mapped = req_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfx_q        <= '0;
      rsp_valid    <= 1'b0;
      rsp_abs      <= '0;
      rsp_prot_exc <= 1'b0;
      rsp_wr_inv   <= 1'b0;
      rsp_bad_mode <= 1'b0;
    end else begin
      if (pfx_we) pfx_q <= pfx_wdata & PFX_MSK;
      rsp_valid    <= req_valid;
      rsp_prot_exc <= req_valid && exc;
      rsp_wr_inv   <= req_valid && inv;
      rsp_bad_mode <= req_valid && bad;
      rsp_abs      <= (req_valid && !exc && !bad) ? mapped : '0;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_EXC_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != K_STORE) |=> !rsp_prot_exc); // R3
  AST_EXC_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot_exc |-> (rsp_abs == '0 && rsp_wr_inv)); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_en) |=> (!rsp_prot_exc && !rsp_wr_inv)); // R4
  AST_BAD_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_bad_mode |-> (!rsp_prot_exc && !rsp_wr_inv && rsp_abs == '0)); // R11
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_prot_exc && !rsp_wr_inv && !rsp_bad_mode)); // R2
endmodule

// File: tb/sim_lowprot_prefix_map.sv
module sim_lowprot_prefix_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        dat_on = 1'b0;
  logic [1:0]  space_mode = '0;
  logic        prot_en = 1'b0;
  logic        priv_primary = 1'b0, priv_secondary = 1'b0, priv_home = 1'b0;
  logic        pfx_we = 1'b0;
  logic [63:0] pfx_wdata = '0;
  logic        rsp_valid, rsp_prot_exc, rsp_wr_inv, rsp_bad_mode;
  logic [63:0] rsp_abs;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic v; logic exc; logic inv; logic bad; logic [63:0] abs;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];
  longint unsigned m_pfx = 0;

  always #10 clk = ~clk;

  lowprot_prefix_map u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .dat_on(dat_on), .space_mode(space_mode),
    .prot_en(prot_en), .priv_primary(priv_primary), .priv_secondary(priv_secondary),
    .priv_home(priv_home), .pfx_we(pfx_we), .pfx_wdata(pfx_wdata),
    .rsp_valid(rsp_valid), .rsp_abs(rsp_abs), .rsp_prot_exc(rsp_prot_exc),
    .rsp_wr_inv(rsp_wr_inv), .rsp_bad_mode(rsp_bad_mode));

  function automatic bit guarded(longint unsigned a);
    return a <= 511 || (a >= 4096 && a <= 4607);
  endfunction

  function automatic exp_t model(bit v, longint unsigned a, int kind, bit dat, int mode,
                                 bit en, bit pp, bit ps, bit ph, longint unsigned pfx);
    exp_t e;
    bit priv, act, bad;
    e = '0;
    if (!v) return e;
    e.v = 1;
    priv = (mode == 0) ? pp : (mode == 2) ? ps : (mode == 3) ? ph : 0;
    bad = dat && mode == 1;
    act = en && !bad && (!dat || !priv);
    e.bad = bad;
    e.inv = act && guarded(a / 4096 * 4096);
    e.exc = e.inv && guarded(a) && kind == 1;
    if (bad || e.exc) e.abs = 0;
    else if (a < 8192) e.abs = a + pfx;
    else if (a >= pfx && a < pfx + 8192) e.abs = a - pfx;
    else e.abs = a;
    return e;
  endfunction

  task automatic compare();
    exp_t e;
    string t;
    if (expq.size() == 0) return;
    e = expq.pop_front();
    t = tagq.pop_front();
    checks++;
    if (rsp_valid !== e.v || rsp_prot_exc !== e.exc || rsp_wr_inv !== e.inv ||
        rsp_bad_mode !== e.bad || rsp_abs !== e.abs) begin
      errors++;
      $display("FAIL %s: got v=%b exc=%b inv=%b bad=%b abs=%h, want v=%b exc=%b inv=%b bad=%b abs=%h",
               t, rsp_valid, rsp_prot_exc, rsp_wr_inv, rsp_bad_mode, rsp_abs,
               e.v, e.exc, e.inv, e.bad, e.abs);
    end
  endtask

  task automatic step(string tag, bit v, longint unsigned a, int kind, bit dat, int mode,
                      bit en, bit pp, bit ps, bit ph, bit we, longint unsigned wd);
    @(negedge clk);
    compare();
    req_valid = v; req_addr = a; req_kind = 2'(kind); dat_on = dat;
    space_mode = 2'(mode); prot_en = en; priv_primary = pp; priv_secondary = ps;
    priv_home = ph; pfx_we = we; pfx_wdata = wd;
    expq.push_back(model(v, a, kind, dat, mode, en, pp, ps, ph, m_pfx));
    tagq.push_back(tag);
    if (we) m_pfx = wd & ~64'h1FFF;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_prot_exc !== 0 || rsp_wr_inv !== 0 || rsp_bad_mode !== 0 || rsp_abs !== 0) begin
      errors++;
      $display("FAIL R1: outputs in reset v=%b exc=%b inv=%b bad=%b abs=%h, want all 0",
               rsp_valid, rsp_prot_exc, rsp_wr_inv, rsp_bad_mode, rsp_abs);
    end
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 1, 64'h10, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 64'h10, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R4", 1, 64'h0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 64'h1005, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 64'h0, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 64'h1FF, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R7", 1, 64'h200, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 64'h1000, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 64'h11FF, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R7", 1, 64'h1200, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R7", 1, 64'h10, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 64'h10, 2, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R7", 1, 64'h2000, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R7", 1, 64'hFFF, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R5", 1, 64'h40, 1, 0, 1, 1, 1, 1, 1, 0, 0);
    step("R6", 1, 64'h40, 1, 1, 0, 1, 1, 0, 0, 0, 0);
    step("R6", 1, 64'h40, 1, 1, 0, 1, 0, 1, 1, 0, 0);
    step("R6", 1, 64'h40, 1, 1, 2, 1, 0, 1, 0, 0, 0);
    step("R6", 1, 64'h40, 1, 1, 2, 1, 1, 0, 1, 0, 0);
    step("R6", 1, 64'h40, 1, 1, 3, 1, 0, 0, 1, 0, 0);
    step("R6", 1, 64'h40, 1, 1, 3, 1, 1, 1, 0, 0, 0);
    step("R11", 1, 64'h40, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    step("R11", 1, 64'h40, 1, 0, 1, 1, 0, 0, 0, 0, 0);
    step("R10", 1, 64'h10, 0, 0, 0, 0, 0, 0, 0, 1, 64'h41FFF);
    step("R8", 1, 64'h10, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 1, 64'h1FFF, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 64'h40010, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 64'h41FFF, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 64'h42000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 64'h3FFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 64'h2000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 64'h100, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R8", 1, 64'h300, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R10", 1, 64'h40010, 0, 0, 0, 0, 0, 0, 0, 1, 64'h7_6000);
    step("R10", 1, 64'h76010, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 64'h40010, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      longint unsigned bases[6] = '{64'h0, 64'h1000, 64'h1E00, 64'h74000, 64'h76000, 64'h78000};
      longint unsigned a;
      int r;
      r = $urandom;
      a = bases[$urandom % 6] + longint'($urandom % 1024) - 64'h100;
      if (a > 64'hF_FFFF) a = 64'h0;
      step("R2", r[0], a, int'($urandom % 3), r[1], r[3:2], r[4], r[5], r[6], r[7],
           (r[15:8] == 8'h5), {$urandom % 64, 13'h0} + 64'h2000);
    end
    @(negedge clk);
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule